// File: doc/BRIEF.md
# Cascaded Halfband Decimator

This block lowers the sample rate of a stream of signed fixed-point samples by a power of two. It chains NUM_STAGES identical halfband FIR stages, and each stage halves the rate of the stage before it. The default of eleven stages gives one output for every 2048 inputs. Each stage has a window of 15 taps. The even-offset taps are symmetric, so the stage folds the four symmetric pairs with pre-adders. It then runs the four pair sums through one multiplier, one product per clock. The centre tap is fixed at one half and is applied as a shift.

Samples enter with a one-clock valid strobe. A stage fires on every second sample it receives. It takes a snapshot of its folded pairs and spends four clocks on the products. It then registers a rounded and saturated result together with its own one-clock strobe, and that strobe feeds the next stage. Inputs must be spaced at least three clocks apart. Under that rule a stage's next snapshot always lands after its previous result has left. Each stage therefore keeps a single multiplier, and the slower stages fill in the idle time left by the faster ones. The four unique coefficients are a parameter.

Top module: `hbd_decim`

## Requirements
- R1: The block emits exactly one output strobe for every 2^NUM_STAGES accepted inputs. After reset, the first output follows input number 2^NUM_STAGES.
- R2: `outValid` is high for exactly one clock per result, and `outData` holds its value between strobes.
- R3: Each stage computes y = c0(x[0]+x[14]) + c1(x[2]+x[12]) + c2(x[4]+x[10]) + c3(x[6]+x[8]) + x[7]/2, bit-exactly, on a full-precision accumulator. Here x[0] is the newest sample in the stage window. The coefficients are signed fractions with FRAC fractional bits, and c0 sits in the least significant COEF_W bits of COEFS.
- R4: The accumulator is rounded to the data width by adding 2^(FRAC-1) and then shifting right arithmetically by FRAC bits.
- R5: A rounded stage result outside the signed DATA_W range is clamped to the largest or smallest representable value.
- R6: With the default coefficients (sum 2^(FRAC-2)), a constant input settles to exactly the same constant at the output, including both full-scale extremes.
- R7: A stage raises its strobe 7 clocks after the clock in which its firing input was valid. The whole chain therefore has a latency of 7*NUM_STAGES clocks.
- R8: Input strobes are separated by at least two idle clocks.
- R9: A synchronous active-low reset clears every window, the stage phases, the output data and the strobe.
- R10: A stage never takes a new snapshot while its multiplier or output step is still busy, and no result is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | One-clock strobe marking a new input sample |
| inData | input | DATA_W | Signed input sample |
| outValid | output | 1 | One-clock strobe marking a decimated result |
| outData | output | DATA_W | Signed decimated result, held between strobes |

## Verification
Assertions inside each stage check the following on every cycle:
- the input spacing;
- the single-clock width of the strobe;
- the fixed delay from snapshot to result;
- that the data holds between strobes;
- that no snapshot collides with a busy multiplier.

The bench's scenarios are needed for what depends on values. These are the bit-exact filter arithmetic, rounding and clamping against an independent model, and unity gain for constant inputs. The scenarios also cover the one-in-four output count across a reset taken mid-stream and the end-to-end latency of the cascade.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  // halfband window: NUM_PAIRS symmetric non-zero pairs plus a centre tap
  localparam int NUM_PAIRS = 4;
  localparam int SPAN      = 4 * NUM_PAIRS - 1;
  localparam int MID       = 2 * NUM_PAIRS - 1;
  localparam int SEL_W     = $clog2(NUM_PAIRS);

  // control -> datapath strobes of one stage
  typedef struct packed {
    logic             shift;  // new sample enters the window
    logic             snap;   // capture folded pairs and centre term
    logic             mac;    // one multiply-accumulate this clock
    logic [SEL_W-1:0] sel;    // pair index for the multiplier
    logic             emit;   // register rounded result
  } hbd_strobe_t;
endpackage

// File: rtl/hbd_ctrl.sv
module hbd_ctrl
  import hbd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output hbd_strobe_t strobe,
  output logic        outValid
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_PAIRS - 1);

  logic             phase;
  logic             pend;
  logic             macOn;
  logic             emitReg;
  logic [SEL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= 1'b0;
      pend     <= 1'b0;
      macOn    <= 1'b0;
      emitReg  <= 1'b0;
      cnt      <= '0;
      outValid <= 1'b0;
    end else begin
      if (inValid) phase <= ~phase;
      pend <= inValid & phase;
      if (pend) begin
        macOn <= 1'b1;
        cnt   <= '0;
      end else if (macOn) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_SEL) macOn <= 1'b0;
      end
      emitReg  <= macOn && (cnt == LAST_SEL) && !pend;
      outValid <= emitReg;
    end
  end

  always_comb begin
    strobe.shift = inValid;
    strobe.snap  = pend;
    strobe.mac   = macOn;
    strobe.sel   = cnt;
    strobe.emit  = emitReg;
  end

  // R8: two idle clocks after every input strobe
  p_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> !inValid ##1 !inValid);

  // R2: result strobe lasts one clock
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R7: result strobe six clocks after the snapshot
  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snap |-> ##6 outValid);

  // R10: snapshot never overlaps a busy multiplier or pending emit
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snap |-> !macOn && !emitReg);
endmodule

// File: rtl/hbd_datapath.sv
module hbd_datapath
  import hbd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 18,
  parameter int FRAC   = 17,
  parameter logic [NUM_PAIRS*COEF_W-1:0] COEFS = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  hbd_strobe_t              strobe,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [DATA_W-1:0] outData
);
  localparam int PAIR_W = DATA_W + 1;
  localparam int PROD_W = PAIR_W + COEF_W;
  localparam int ACC_W  = PROD_W + 3;
  localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [DATA_W-1:0] taps    [SPAN];
  logic signed [PAIR_W-1:0] pairSum [NUM_PAIRS];
  logic signed [PAIR_W-1:0] pairReg [NUM_PAIRS];
  logic signed [COEF_W-1:0] coefTab [NUM_PAIRS];
  logic signed [PAIR_W-1:0] pairSel;
  logic signed [COEF_W-1:0] coefSel;
  logic signed [PROD_W-1:0] prodNow;
  logic signed [ACC_W-1:0]  midTerm;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accRnd;
  logic signed [ACC_W-1:0]  accShift;
  logic signed [DATA_W-1:0] satVal;

  // fold symmetric taps; unpack coefficients
  for (genvar j = 0; j < NUM_PAIRS; j++) begin : g_pair
    assign pairSum[j] = PAIR_W'(taps[2*j]) + PAIR_W'(taps[SPAN-1-2*j]);
    assign coefTab[j] = COEFS[j*COEF_W +: COEF_W];
  end

  assign pairSel  = pairReg[strobe.sel];
  assign coefSel  = coefTab[strobe.sel];
  assign prodNow  = pairSel * coefSel;
  assign midTerm  = ACC_W'(taps[MID]) <<< (FRAC - 1);
  assign accRnd   = acc + HALF;
  assign accShift = accRnd >>> FRAC;

  always_comb begin
    if (accShift > SAT_HI)      satVal = SAT_HI[DATA_W-1:0];
    else if (accShift < SAT_LO) satVal = SAT_LO[DATA_W-1:0];
    else                        satVal = accShift[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SPAN; i++) taps[i] <= '0;
      for (int j = 0; j < NUM_PAIRS; j++) pairReg[j] <= '0;
      acc     <= '0;
      outData <= '0;
    end else begin
      if (strobe.shift) begin
        taps[0] <= inData;
        for (int i = 1; i < SPAN; i++) taps[i] <= taps[i-1];
      end
      if (strobe.snap) begin
        for (int j = 0; j < NUM_PAIRS; j++) pairReg[j] <= pairSum[j];
        acc <= midTerm;
      end else if (strobe.mac) begin
        acc <= acc + ACC_W'(prodNow);
      end
      if (strobe.emit) outData <= satVal;
    end
  end

  // R2: data moves only on an emit strobe
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> $stable(outData));

  // R10: multiplier idle while a snapshot is captured
  p_snap_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snap |-> !strobe.mac);
endmodule

// File: rtl/hbd_decim.sv
module hbd_decim
  import hbd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_STAGES = 11,
  parameter int COEF_W     = 18,
  parameter int FRAC       = 17,
  parameter logic [NUM_PAIRS*COEF_W-1:0] COEFS =
    {18'sd38969, -18'sd8183, 18'sd2424, -18'sd442}
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData
);
  logic [NUM_STAGES:0]      vChain;
  logic signed [DATA_W-1:0] dChain [NUM_STAGES+1];

  assign vChain[0] = inValid;
  assign dChain[0] = inData;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    hbd_strobe_t stb;

    hbd_ctrl u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .inValid  (vChain[s]),
      .strobe   (stb),
      .outValid (vChain[s+1])
    );

    hbd_datapath #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .FRAC   (FRAC),
      .COEFS  (COEFS)
    ) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (stb),
      .inData  (dChain[s]),
      .outData (dChain[s+1])
    );
  end

  assign outValid = vChain[NUM_STAGES];
  assign outData  = dChain[NUM_STAGES];
endmodule

// File: tb/hbd_decim_bench.sv
module hbd_decim_bench;
  localparam int STG = 2;
  localparam int DW  = 16;
  localparam int GAP = 4;
  localparam int DC_N = 6;
  localparam int DC_TAB [DC_N][2] = '{
    '{0, 0}, '{1000, 1000}, '{-1000, -1000},
    '{32767, 32767}, '{-32768, -32768}, '{12345, 12345}};
  localparam longint CF [4] = '{-442, 2424, -8183, 38969};

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic signed [DW-1:0] inData = '0;
  logic                 outValid;
  logic signed [DW-1:0] outData;

  always #2 clk = ~clk;

  hbd_decim #(.DATA_W(DW), .NUM_STAGES(STG)) u_hbd_decim (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData));

  int     total = 0;
  int     bad = 0;
  longint cyc = 0;
  longint lastInCyc = 0;
  longint lastOutCyc = 0;
  int     nGot = 0;
  int     lastOut = 0;
  bit     prevOut = 1'b0;
  string  curReq = "R3";
  int     expQ [0:8191];
  int     wrIdx = 0;
  int     rdIdx = 0;
  int     mTap [STG][15];
  bit     mPh [STG];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint got, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic int stageCalc(int s);
    longint a = longint'(mTap[s][7]) <<< 16;
    for (int j = 0; j < 4; j++)
      a += CF[j] * longint'(mTap[s][2*j] + mTap[s][14-2*j]);
    a = (a + 65536) >>> 17;
    if (a > 32767) a = 32767;
    if (a < -32768) a = -32768;
    return int'(a);
  endfunction

  task automatic modelPush(int x);
    int v = x;
    for (int s = 0; s < STG; s++) begin
      for (int t = 14; t > 0; t--) mTap[s][t] = mTap[s][t-1];
      mTap[s][0] = v;
      if (!mPh[s]) begin
        mPh[s] = 1'b1;
        return;
      end
      mPh[s] = 1'b0;
      v = stageCalc(s);
    end
    expQ[wrIdx] = v;
    wrIdx++;
  endtask

  task automatic modelClear();
    for (int s = 0; s < STG; s++) begin
      mPh[s] = 1'b0;
      for (int t = 0; t < 15; t++) mTap[s][t] = 0;
    end
    rdIdx = wrIdx;
  endtask

  task automatic push(int x);
    @(negedge clk);
    inValid = 1'b1;
    inData = DW'(x);
    lastInCyc = cyc;
    modelPush(x);
    @(negedge clk);
    inValid = 1'b0;
    repeat (GAP - 2) @(negedge clk);
  endtask

  task automatic drain();
    repeat (8 * STG + 8) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    modelClear();
    rstN = 1'b1;
  endtask

  // output monitor: compares every result with the model
  always @(negedge clk) begin
    if (rstN && outValid) begin
      check(!prevOut, "R2", "strobe wider than one clock", 1, 0);
      if (rdIdx >= wrIdx) begin
        check(1'b0, "R10", "unexpected result", outData, 0);
      end else begin
        check(int'(outData) == expQ[rdIdx], curReq, "result value", outData, expQ[rdIdx]);
        rdIdx++;
      end
      nGot++;
      lastOut = int'(outData);
      lastOutCyc = cyc;
    end
    prevOut = rstN && outValid;
  end

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got=running expected=finished");
    report();
    $finish;
  end

  initial begin
    int got0;
    int lfsr;
    modelClear();
    repeat (4) @(negedge clk);
    // R9: reset state
    check(outValid == 1'b0, "R9", "outValid in reset", outValid, 0);
    check(outData == '0, "R9", "outData in reset", outData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R7: first result after input 2^STG, latency 7 per stage
    curReq = "R1";
    got0 = nGot;
    for (int i = 0; i < 3; i++) push(500 * (i + 1));
    drain();
    check(nGot == got0, "R1", "outputs before 4th input", nGot - got0, 0);
    push(2000);
    drain();
    check(nGot == got0 + 1, "R1", "outputs after 4th input", nGot - got0, 1);
    check(lastOutCyc - lastInCyc == 7 * STG, "R7", "chain latency", lastOutCyc - lastInCyc, 7 * STG);

    // R6: DC table walk
    curReq = "R6";
    for (int k = 0; k < DC_N; k++) begin
      for (int i = 0; i < 80; i++) push(DC_TAB[k][0]);
      drain();
      check(lastOut == DC_TAB[k][1], "R6", "settled DC output", lastOut, DC_TAB[k][1]);
    end

    // R3: impulse response through the cascade
    doReset();
    curReq = "R3";
    push(32767);
    for (int i = 0; i < 63; i++) push(0);
    drain();

    // R3 / R4: pseudo-random samples, bit-exact rounding
    curReq = "R4";
    lfsr = 32'h1ACE5EED;
    for (int i = 0; i < 400; i++) begin
      lfsr ^= lfsr << 13;
      lfsr ^= lfsr >>> 17 & 32'h00007FFF;
      lfsr ^= lfsr << 5;
      push(int'($signed(lfsr[15:0])));
    end
    drain();

    // R5: sign-matched full scale, positive then negative
    curReq = "R5";
    for (int pol = 0; pol < 2; pol++) begin
      doReset();
      push(0);
      for (int k = 0; k < 15; k++) begin
        bit neg = (k == 0) || (k == 4) || (k == 10) || (k == 14);
        int f = (pol == 0) ? 32767 : -32768;
        push(neg ? ((pol == 0) ? -32768 : 32767) : f);
      end
      for (int i = 0; i < 48; i++) push(0);
      drain();
    end

    // R9 / R1: reset mid-stream restarts the phase count
    curReq = "R9";
    push(700);
    push(-700);
    doReset();
    got0 = nGot;
    for (int i = 0; i < 3; i++) push(100);
    drain();
    check(nGot == got0, "R9", "outputs after reset, 3 inputs", nGot - got0, 0);
    push(100);
    drain();
    check(nGot == got0 + 1, "R9", "outputs after reset, 4 inputs", nGot - got0, 1);

    // R10 / R8: every modelled result arrived, inputs kept spacing GAP
    check(rdIdx == wrIdx, "R10", "results delivered", rdIdx, wrIdx);
    check(GAP >= 3, "R8", "input spacing used", GAP, 3);

    report();
    $finish;
  end
endmodule